// File: doc/BRIEF.md
# Per-Channel Signaling and Trunk Conditioning Inserter

This block sits in the transmit path of a 24-channel T1/J1 line, upstream of the framer. Each channel byte arrives with its channel number and the number of the frame it belongs to. In the frames that carry signaling, the block can overwrite the least significant bit of each channel. The new bit comes from a serial signaling nibble supplied beside the data or from per-channel A/B/C/D bits held in a register table. Which of these applies, if any, is chosen separately for every channel.

Trunk conditioning replaces the whole channel byte with a per-channel idle code. It is honoured only while the master per-channel control enable is set. Signaling substitution still applies on top of the idle code. A freeze option makes every robbed-bit frame use the signaling captured in frame 0 of the current superframe, so a signaling change cannot appear partway through a superframe.

A single write port loads the two per-channel tables: a signaling-control word and an idle code. Every result leaves through one register stage.

Top module: `tsi_top`

## Requirements
- R1: `out_valid` equals `ch_valid` one clock earlier, and `out_data` is the processed byte one clock after its input.
- R2: For a byte outside a signaling frame with trunk conditioning inactive, `out_data` equals `ch_data`. Bits 7..1 are never altered unless trunk conditioning is active.
- R3: Frame numbers count from 0. In SF mode (`esf_mode`=0), frame 5 carries A and frame 11 carries B. In ESF mode, frames 5, 11, 17 and 23 carry A, B, C and D. Substitution replaces only bit 0 of the byte.
- R4: The signaling-control word uses bits [7:6] as the source select and bits [3:0] as A,B,C,D (A in bit 3, D in bit 0). The select values are: 00 and 01 pass bit 0 through unchanged, 10 takes the bit from `ext_sig`, and 11 takes it from the register bits. `ext_sig` uses the same A-in-bit-3 order.
- R5: In frame 0, each valid byte with a channel number in range stores that channel's selected signaling nibble. While `freeze_en` is 1, signaling frames use this stored nibble in place of the live one.
- R6: When `pcc_en` and `trunk_en` are both 1, the byte is replaced by that channel's idle code. In signaling frames, bit 0 of the idle code is still replaced according to the channel's select.
- R7: `trunk_en` has no effect while `pcc_en` is 0.
- R8: With `cfg_we`=1, `cfg_wdata` is written to the table chosen by `cfg_tbl` (0 = signaling control, 1 = idle code) at entry `cfg_ch`. A byte in the same cycle still sees the old value, and the byte in the next cycle sees the new value.
- R9: A byte whose `ch_idx` is 24 or above passes through unchanged, whatever the mode.
- R10: After reset, `out_valid` and `out_data` are 0, every select is 00, and every idle code is 8'h7F.
- R11: In SF mode, frames 12 and above are never signaling frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_valid | input | 1 | Channel byte present this cycle |
| frame_idx | input | 5 | Frame number within the superframe, from 0 |
| ch_idx | input | 5 | Channel number, from 0 |
| ch_data | input | 8 | Channel byte |
| ext_sig | input | 4 | External signaling nibble for this channel (A in bit 3) |
| esf_mode | input | 1 | 1 = 24-frame superframe, 0 = 12-frame superframe |
| freeze_en | input | 1 | Use the signaling captured in frame 0 |
| pcc_en | input | 1 | Master per-channel control enable |
| trunk_en | input | 1 | Trunk conditioning request |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl | input | 1 | Table select: 0 signaling control, 1 idle code |
| cfg_ch | input | 5 | Table entry to write |
| cfg_wdata | input | 8 | Write data |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Processed channel byte |

## Verification
A corrupted table entry or a stale frozen nibble shows up only in the bytes of the channel concerned. It appears on the very next byte of that channel in a signaling frame, or on any byte of that channel under trunk conditioning. A wrong signaling frame decode moves bit 0 in the wrong frame, and this is visible one cycle after that byte enters. For this reason the stimulus covers every signaling frame in both superframe lengths, each source select, and trunk conditioning with and without the master enable. Capture and write timing are checked on the cycle next to the event.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
   typedef enum logic [1:0] {
      SRC_PASS     = 2'b00,
      SRC_PASS_ALT = 2'b01,
      SRC_EXT      = 2'b10,
      SRC_REG      = 2'b11
   } sig_src_e;

   localparam int SEL_HI = 7;
   localparam int SEL_LO = 6;
   localparam logic TBL_SIG  = 1'b0;
   localparam logic TBL_IDLE = 1'b1;
endpackage

// File: rtl/tsi_cfg_tables.sv
module tsi_cfg_tables #(
   parameter int NUM_CH   = 24,
   parameter int CH_W     = 5,
   parameter int BYTE_W   = 8,
   parameter logic [BYTE_W-1:0] IDLE_RST = 8'h7F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_tbl,
   input  logic [CH_W-1:0]   wr_ch,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [CH_W-1:0]   rd_ch,
   output logic [BYTE_W-1:0] rd_ctrl,
   output logic [BYTE_W-1:0] rd_idle
);
   import tsi_pkg::*;

   logic [NUM_CH-1:0][BYTE_W-1:0] ctrl_q;
   logic [NUM_CH-1:0][BYTE_W-1:0] idle_q;

   for (genvar e = 0; e < NUM_CH; e++) begin : g_entry
      logic hit;
      assign hit = wr_en && (wr_ch == CH_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_q[e] <= '0;
            idle_q[e] <= IDLE_RST;
         end else if (hit) begin
            if (wr_tbl == TBL_IDLE) idle_q[e] <= wr_data;
            else                    ctrl_q[e] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_ctrl = '0;
      rd_idle = IDLE_RST;
      if (32'(rd_ch) < NUM_CH) begin
         rd_ctrl = ctrl_q[rd_ch];
         rd_idle = idle_q[rd_ch];
      end
   end

   // R8: a write lands in the addressed entry of the chosen table
   a_r8_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_tbl == TBL_IDLE && 32'(wr_ch) < NUM_CH)
      |=> idle_q[$past(wr_ch)] == $past(wr_data));
   a_r8_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_tbl == TBL_SIG && 32'(wr_ch) < NUM_CH)
      |=> ctrl_q[$past(wr_ch)] == $past(wr_data));
endmodule

// File: rtl/tsi_sig_freeze.sv
module tsi_sig_freeze #(
   parameter int NUM_CH = 24,
   parameter int CH_W   = 5,
   parameter int SIG_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic [CH_W-1:0]  cap_ch,
   input  logic [SIG_W-1:0] cap_val,
   input  logic [CH_W-1:0]  rd_ch,
   output logic [SIG_W-1:0] rd_val
);
   logic [NUM_CH-1:0][SIG_W-1:0] frz_q;

   for (genvar e = 0; e < NUM_CH; e++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                frz_q[e] <= '0;
         else if (cap_en && cap_ch == CH_W'(e))     frz_q[e] <= cap_val;
      end
   end

   always_comb begin
      rd_val = '0;
      if (32'(rd_ch) < NUM_CH) rd_val = frz_q[rd_ch];
   end

   // R5: stored signaling only moves on a frame-0 capture
   a_r5_hold_outside_capture: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(frz_q));
endmodule

// File: rtl/tsi_slot_decode.sv
module tsi_slot_decode #(
   parameter int FRAME_W    = 5,
   parameter int ROB_PERIOD = 6,
   parameter int SF_LEN     = 12,
   parameter int ESF_LEN    = 24,
   parameter int SIG_W      = 4,
   localparam int SLOT_W    = (SIG_W > 1) ? $clog2(SIG_W) : 1
) (
   input  logic [FRAME_W-1:0] frame_idx,
   input  logic               esf_mode,
   output logic               robbed,
   output logic [SLOT_W-1:0]  slot
);
   localparam int SF_SLOTS = SF_LEN / ROB_PERIOD;

   logic [SIG_W-1:0] hit;

   for (genvar k = 0; k < SIG_W; k++) begin : g_hit
      localparam int FR = (k + 1) * ROB_PERIOD - 1;
      if (k < SF_SLOTS) begin : g_both
         assign hit[k] = (32'(frame_idx) == FR);
      end else begin : g_esf_only
         assign hit[k] = esf_mode && (32'(frame_idx) == FR);
      end
   end

   always_comb begin
      slot = '0;
      for (int k = 0; k < SIG_W; k++)
         if (hit[k]) slot = SLOT_W'(k);
   end
   assign robbed = |hit;
endmodule

// File: rtl/tsi_top.sv
module tsi_top #(
   parameter int NUM_CH     = 24,
   parameter int BYTE_W     = 8,
   parameter int SIG_W      = 4,
   parameter int ROB_PERIOD = 6,
   parameter int SF_LEN     = 12,
   parameter int ESF_LEN    = 24,
   parameter logic [BYTE_W-1:0] IDLE_RST = 8'h7F,
   localparam int CH_W      = $clog2(NUM_CH),
   localparam int FRAME_W   = $clog2(ESF_LEN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ch_valid,
   input  logic [FRAME_W-1:0] frame_idx,
   input  logic [CH_W-1:0]    ch_idx,
   input  logic [BYTE_W-1:0]  ch_data,
   input  logic [SIG_W-1:0]   ext_sig,
   input  logic               esf_mode,
   input  logic               freeze_en,
   input  logic               pcc_en,
   input  logic               trunk_en,
   input  logic               cfg_we,
   input  logic               cfg_tbl,
   input  logic [CH_W-1:0]    cfg_ch,
   input  logic [BYTE_W-1:0]  cfg_wdata,
   output logic               out_valid,
   output logic [BYTE_W-1:0]  out_data
);
   import tsi_pkg::*;

   localparam int SLOT_W = (SIG_W > 1) ? $clog2(SIG_W) : 1;

   initial begin : p_param_chk
      assert (NUM_CH >= 1) else $fatal(1, "NUM_CH must be positive");
      assert (BYTE_W >= 8) else $fatal(1, "control word needs 8 bits");
      assert (SIG_W * ROB_PERIOD == ESF_LEN) else $fatal(1, "slots must tile the long superframe");
      assert (SF_LEN % ROB_PERIOD == 0) else $fatal(1, "short superframe must hold whole slots");
   end

   logic [BYTE_W-1:0] ctrl_w, idle_w, nxt_data;
   logic [SIG_W-1:0]  frz_w, live_w, use_w;
   logic [SLOT_W-1:0] slot_w;
   logic              robbed_w, ch_ok, trunk_act, cap_en;
   sig_src_e          src_w;

   assign ch_ok     = 32'(ch_idx) < NUM_CH;
   assign trunk_act = pcc_en && trunk_en && ch_ok;
   assign cap_en    = ch_valid && ch_ok && (frame_idx == '0);

   tsi_cfg_tables #(.NUM_CH(NUM_CH), .CH_W(CH_W), .BYTE_W(BYTE_W), .IDLE_RST(IDLE_RST)) tables_i (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_tbl(cfg_tbl), .wr_ch(cfg_ch),
      .wr_data(cfg_wdata), .rd_ch(ch_idx), .rd_ctrl(ctrl_w), .rd_idle(idle_w));

   tsi_slot_decode #(.FRAME_W(FRAME_W), .ROB_PERIOD(ROB_PERIOD), .SF_LEN(SF_LEN),
                     .ESF_LEN(ESF_LEN), .SIG_W(SIG_W)) slots_i (
      .frame_idx(frame_idx), .esf_mode(esf_mode), .robbed(robbed_w), .slot(slot_w));

   assign src_w  = sig_src_e'(ctrl_w[SEL_HI:SEL_LO]);
   assign live_w = (src_w == SRC_EXT) ? ext_sig : ctrl_w[SIG_W-1:0];

   tsi_sig_freeze #(.NUM_CH(NUM_CH), .CH_W(CH_W), .SIG_W(SIG_W)) freeze_i (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_ch(ch_idx), .cap_val(live_w),
      .rd_ch(ch_idx), .rd_val(frz_w));

   assign use_w = freeze_en ? frz_w : live_w;

   always_comb begin
      nxt_data = trunk_act ? idle_w : ch_data;
      if (ch_ok && robbed_w && (src_w == SRC_EXT || src_w == SRC_REG))
         nxt_data[0] = use_w[SIG_W-1-32'(slot_w)];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= ch_valid;
         out_data  <= nxt_data;
      end
   end

   // R1: output strobe trails the input strobe by one cycle
   a_r1_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> out_valid == $past(ch_valid));
   // R2: untouched bytes pass unchanged
   a_r2_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_valid && !robbed_w && !(pcc_en && trunk_en)) |=> out_data == $past(ch_data));
   // R3: signaling only ever touches bit 0
   a_r3_lsb_only: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_valid && !(pcc_en && trunk_en)) |=> out_data[BYTE_W-1:1] == $past(ch_data[BYTE_W-1:1]));
   // R11: no signaling frame beyond the short superframe
   a_r11_sf_range: assert property (@(posedge clk) disable iff (!rst_n)
      (!esf_mode && 32'(frame_idx) >= SF_LEN) |-> !robbed_w);
   // R9: out-of-range channels are left alone
   a_r9_bad_channel: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_valid && !ch_ok) |=> out_data == $past(ch_data));
endmodule

// File: tb/tsi_top_tb_top.sv
module tsi_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ch_valid = 1'b0;
   logic [4:0] frame_idx = '0, ch_idx = '0, cfg_ch = '0;
   logic [7:0] ch_data = '0, cfg_wdata = '0;
   logic [3:0] ext_sig = '0;
   logic       esf_mode = 0, freeze_en = 0, pcc_en = 0, trunk_en = 0;
   logic       cfg_we = 0, cfg_tbl = 0;
   logic       out_valid;
   logic [7:0] out_data;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   tsi_top dut_i (.clk, .rst_n, .ch_valid, .frame_idx, .ch_idx, .ch_data, .ext_sig,
      .esf_mode, .freeze_en, .pcc_en, .trunk_en, .cfg_we, .cfg_tbl, .cfg_ch, .cfg_wdata,
      .out_valid, .out_data);

   // vector: frame, ch, data, ext, esf, frz, pcc, trk, expected
   localparam int NV = 20;
   localparam logic [33:0] VEC [NV] = '{
      {5'd0,  5'd5,  8'h55, 4'hF,    1'b0,1'b0,1'b0,1'b0, 8'h55}, // R2
      {5'd5,  5'd5,  8'h54, 4'hF,    1'b0,1'b0,1'b0,1'b0, 8'h54}, // R4 pass
      {5'd5,  5'd3,  8'h54, 4'b1000, 1'b0,1'b0,1'b0,1'b0, 8'h55}, // R3 A ext
      {5'd11, 5'd3,  8'h55, 4'b1011, 1'b0,1'b0,1'b0,1'b0, 8'h54}, // R3 B ext
      {5'd17, 5'd3,  8'h20, 4'b0010, 1'b1,1'b0,1'b0,1'b0, 8'h21}, // R3 C esf
      {5'd23, 5'd3,  8'h21, 4'b1110, 1'b1,1'b0,1'b0,1'b0, 8'h20}, // R3 D esf
      {5'd17, 5'd3,  8'h20, 4'b0010, 1'b0,1'b0,1'b0,1'b0, 8'h20}, // R11
      {5'd23, 5'd3,  8'h21, 4'b1110, 1'b0,1'b0,1'b0,1'b0, 8'h21}, // R11
      {5'd5,  5'd4,  8'h00, 4'h0,    1'b0,1'b0,1'b0,1'b0, 8'h01}, // R4 reg A
      {5'd11, 5'd4,  8'hFF, 4'hF,    1'b0,1'b0,1'b0,1'b0, 8'hFE}, // R4 reg B
      {5'd17, 5'd4,  8'h00, 4'h0,    1'b1,1'b0,1'b0,1'b0, 8'h01}, // R4 reg C
      {5'd23, 5'd4,  8'hFF, 4'hF,    1'b1,1'b0,1'b0,1'b0, 8'hFE}, // R4 reg D
      {5'd6,  5'd4,  8'h00, 4'hF,    1'b1,1'b0,1'b0,1'b0, 8'h00}, // R2 non-slot
      {5'd0,  5'd3,  8'h12, 4'h0,    1'b0,1'b0,1'b1,1'b1, 8'hA5}, // R6 idle
      {5'd5,  5'd3,  8'h12, 4'b0111, 1'b0,1'b0,1'b1,1'b1, 8'hA4}, // R6 sig on idle
      {5'd5,  5'd4,  8'h12, 4'h0,    1'b0,1'b0,1'b1,1'b1, 8'h3D}, // R6 reg on idle
      {5'd0,  5'd7,  8'h12, 4'h0,    1'b0,1'b0,1'b1,1'b1, 8'h7F}, // R10 idle reset
      {5'd0,  5'd3,  8'h12, 4'h0,    1'b0,1'b0,1'b0,1'b1, 8'h12}, // R7
      {5'd5,  5'd30, 8'h10, 4'hF,    1'b0,1'b0,1'b1,1'b1, 8'h10}, // R9
      {5'd5,  5'd24, 8'h10, 4'hF,    1'b1,1'b0,1'b0,1'b0, 8'h10}  // R9
   };

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(logic [4:0] f, logic [4:0] c, logic [7:0] d, logic [3:0] e,
                        logic esf, logic frz, logic pcc, logic trk);
      @(negedge clk);
      ch_valid = 1; frame_idx = f; ch_idx = c; ch_data = d; ext_sig = e;
      esf_mode = esf; freeze_en = frz; pcc_en = pcc; trunk_en = trk;
   endtask

   task automatic send(string req, logic [4:0] f, logic [4:0] c, logic [7:0] d, logic [3:0] e,
                       logic esf, logic frz, logic pcc, logic trk, logic [7:0] exp);
      drive(f, c, d, e, esf, frz, pcc, trk);
      @(negedge clk);
      ch_valid = 0;
      check(req, out_data, exp);
   endtask

   task automatic cfg_write(logic tbl, logic [4:0] c, logic [7:0] w);
      @(negedge clk);
      cfg_we = 1; cfg_tbl = tbl; cfg_ch = c; cfg_wdata = w;
      @(negedge clk);
      cfg_we = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R10 out_valid", {7'd0, out_valid}, 8'h00);
      check("R10 out_data", out_data, 8'h00);
      rst_n = 1;
      @(negedge clk);
      // R10: select 00 after reset, slot left untouched
      send("R10 sel reset", 5'd5, 5'd9, 8'h00, 4'hF, 0, 0, 0, 0, 8'h00);
      // R1: valid timing
      drive(5'd1, 5'd1, 8'h33, 4'h0, 0, 0, 0, 0);
      @(negedge clk);
      check("R1 valid", {7'd0, out_valid}, 8'h01);
      ch_valid = 0;
      @(negedge clk);
      check("R1 idle", {7'd0, out_valid}, 8'h00);

      cfg_write(1'b0, 5'd3, 8'h80);   // ext source
      cfg_write(1'b0, 5'd4, 8'hCA);   // reg source, ABCD=1010
      cfg_write(1'b1, 5'd3, 8'hA5);
      cfg_write(1'b1, 5'd4, 8'h3C);

      for (int i = 0; i < NV; i++) begin
         send($sformatf("vector %0d (R1-tagged table)", i), VEC[i][33:29], VEC[i][28:24],
              VEC[i][23:16], VEC[i][15:12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8],
              VEC[i][7:0]);
      end

      // R5: freeze
      send("R5 capture", 5'd0, 5'd3, 8'h40, 4'b0000, 0, 1, 0, 0, 8'h40);
      send("R5 frozen A", 5'd5, 5'd3, 8'h40, 4'b1111, 0, 1, 0, 0, 8'h40);
      send("R5 live A", 5'd5, 5'd3, 8'h40, 4'b1111, 0, 0, 0, 0, 8'h41);
      send("R5 recapture", 5'd0, 5'd3, 8'h40, 4'b1111, 1, 1, 0, 0, 8'h40);
      send("R5 frozen B", 5'd11, 5'd3, 8'h40, 4'b0000, 1, 1, 0, 0, 8'h41);
      send("R5 frozen D", 5'd23, 5'd3, 8'h40, 4'b0000, 1, 1, 0, 0, 8'h41);

      // R8: write and byte in the same cycle, then the next cycle
      @(negedge clk);
      cfg_we = 1; cfg_tbl = 1; cfg_ch = 5'd7; cfg_wdata = 8'h5A;
      ch_valid = 1; frame_idx = 0; ch_idx = 5'd7; ch_data = 8'h00; ext_sig = 0;
      esf_mode = 0; freeze_en = 0; pcc_en = 1; trunk_en = 1;
      @(negedge clk);
      cfg_we = 0;
      check("R8 same cycle old", out_data, 8'h7F);
      @(negedge clk);
      ch_valid = 0;
      check("R8 next cycle new", out_data, 8'h5A);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule